// File: doc/BRIEF.md
# Converter Result Serial Output Controller

This block is the digital back end of a 16-bit successive-approximation converter. Each time the conversion engine raises a one-cycle completion strobe, the block takes the result (offset binary), applies the selected output coding and shifts the word out most significant bit first on one serial data line. Two mode selects pick one of four output modes. One select chooses the serial clock source: a clock supplied from outside, or a clock the block makes itself from the master clock. The other select chooses when the word goes out: at once on completion, or one conversion later (pipelined).

In pipelined delivery the finished word is held until the next conversion starts, signalled by a falling edge on the active-low hold input. That edge moves the held word into the shifter. Any bits of the previous word that have not been sent are thrown away. When the serial clock is external, it is brought into the master-clock domain through a synchroniser and its falling edges advance the shifter. When it is internal, the block sends exactly one burst of clock pulses per word at a quarter of the master clock rate and then rests high.

Top module: `adc_serial_out`

## Requirements
- R1: During and after a synchronous active-high reset, with no word loaded, sdata is 1, busy is 0 and sclk_out is 1.
- R2: sclk_oe is 1 when sel_ext_clk is 0 (internal clock) and 0 when sel_ext_clk is 1.
- R3: Words leave MSB first. In external-clock mode, each falling edge of sclk_in, once it has passed a two-stage synchroniser, shifts the next bit onto sdata on the third master-clock edge after sclk_in is first sampled low.
- R4: Serial clock falling edges after the sixteenth bit of a word, or while no word is loaded, leave sdata at 1.
- R5: In internal-clock mode, each word produces exactly 16 sclk_out periods. Each period is 2 master clocks low and then 2 high, and the next bit appears on sdata as sclk_out falls. After the last period sclk_out stays high.
- R6: With sel_pipelined=0, a result strobe puts the new word's MSB on sdata at the clock edge that samples the strobe, and replaces any word still being shifted.
- R7: With sel_pipelined=1, a result is held and nothing of it is sent until a hold_n falling edge (1 then 0 on consecutive clock samples). That edge loads the held word into the shifter.
- R8: With sel_pipelined=1, a hold_n falling edge that finds a held word while a previous word is still being shifted discards the unsent bits and starts the held word.
- R9: code_twos=0 sends the result unchanged (offset binary). code_twos=1 sends it with bit 15 inverted (two's complement).
- R10: busy is 1 from the load of a word until the shift that sends out its sixteenth bit, and 0 otherwise.
- R11: In internal-clock mode, activity on sclk_in has no effect on sdata, busy or sclk_out.
- R12: With sel_pipelined=1, a hold_n falling edge with no held word leaves a shift in progress untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_ext_clk | input | 1 | 1: serial clock comes in on sclk_in; 0: block drives sclk_out |
| sel_pipelined | input | 1 | 1: send the word during the next conversion; 0: send it at once |
| code_twos | input | 1 | 1: two's complement output; 0: offset binary |
| hold_n | input | 1 | Active-low conversion start; its falling edge releases a held word |
| res_valid | input | 1 | One-cycle conversion-complete strobe |
| res_data | input | 16 | Conversion result in offset binary |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Internally generated serial clock, idle high |
| sclk_oe | output | 1 | Output enable for sclk_out |
| sdata | output | 1 | Serial data, MSB first |
| busy | output | 1 | A word is being shifted |

## Verification
A behavioural model in the bench predicts sdata, busy and both clock pins on every cycle. Directed passes target the cases a plausible design gets wrong. A synchroniser off by one stage shifts early or late. A missing ones fill lets surplus clocks leak stale bits. A pipelined path that sends on completion instead of on the hold edge puts data out one conversion too early. A hold edge with nothing held that still restarts the shifter corrupts a word part-way through. A divider of the wrong length gives more or fewer than sixteen pulses, and an internal mode that still listens to sclk_in shifts on stray edges. A coding step that flips the wrong bit shows in the two's complement passes.

// File: rtl/aso_pkg.sv
package aso_pkg;

    localparam int WORD_W = 16;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic clk_ext;
        logic pipelined;
    } mode_t;

    typedef struct packed {
        logic  valid;
        word_t word;
    } word_xfer_t;

    typedef enum logic {
        SH_IDLE  = 1'b0,
        SH_SHIFT = 1'b1
    } sh_state_e;

    // Offset binary to two's complement differs only in the top bit.
    function automatic word_t apply_coding(input word_t ob, input logic twos);
        return {ob[WORD_W-1] ^ twos, ob[WORD_W-2:0]};
    endfunction

endpackage

// File: rtl/aso_edge_sync.sv
module aso_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic hold_n,
    output logic sclk_fall,
    output logic hold_fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sclk_prev;
    logic                   hold_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= sclk_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            hold_prev <= 1'b1;
        end else begin
            sclk_prev <= sync_q[SYNC_STAGES-1];
            hold_prev <= hold_n;
        end
    end

    assign sclk_fall = sclk_prev & ~sync_q[SYNC_STAGES-1];
    assign hold_fall = hold_prev & ~hold_n;

    // A synchronised falling edge lasts one master cycle only.
    p_fall_single_r3: assert property (@(posedge clk) disable iff (rst)
        sclk_fall |=> !sclk_fall);

endmodule

// File: rtl/aso_stage.sv
module aso_stage
    import aso_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mode_t      mode,
    input  logic       code_twos,
    input  logic       res_valid,
    input  word_t      res_data,
    input  logic       hold_fall,
    output word_xfer_t load
);
    word_t coded;
    word_t pend_q;
    logic  pend_v;

    assign coded = apply_coding(res_data, code_twos);

    always_comb begin
        if (mode.pipelined) begin
            load.valid = hold_fall & pend_v;
            load.word  = pend_q;
        end else begin
            load.valid = res_valid;
            load.word  = coded;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            pend_v <= 1'b0;
        end else if (mode.pipelined) begin
            if (res_valid) begin
                pend_q <= coded;
                pend_v <= 1'b1;
            end else if (load.valid) begin
                pend_v <= 1'b0;
            end
        end else begin
            pend_v <= 1'b0;
        end
    end

    // A held word is released once and not again.
    p_pend_consumed_r7: assert property (@(posedge clk) disable iff (rst)
        (mode.pipelined && load.valid && !res_valid) |=> !pend_v);

    // Immediate delivery never leaves a word waiting.
    p_imm_no_pend_r6: assert property (@(posedge clk) disable iff (rst)
        !mode.pipelined |=> !pend_v);

endmodule

// File: rtl/aso_shifter.sv
module aso_shifter
    import aso_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_ext,
    input  word_xfer_t load,
    input  logic       sclk_fall,
    output logic       sdata,
    output logic       busy,
    output logic       sclk_out
);
    localparam int HALF = CLK_DIV / 2;
    localparam int PH_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    sh_state_e        state;
    word_t            shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic [PH_W-1:0]  phase;
    logic             step;
    logic             last_ph;

    assign last_ph = (phase == PH_W'(CLK_DIV - 1));
    assign step    = (state == SH_SHIFT) && (clk_ext ? sclk_fall : last_ph);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SH_IDLE;
            shreg   <= '1;
            bit_cnt <= '0;
            phase   <= '0;
        end else if (load.valid) begin
            state   <= SH_SHIFT;
            shreg   <= load.word;
            bit_cnt <= '0;
            phase   <= '0;
        end else begin
            if (state == SH_SHIFT && !clk_ext)
                phase <= last_ph ? '0 : phase + 1'b1;
            if (step) begin
                shreg <= {shreg[WORD_W-2:0], 1'b1};
                if (bit_cnt == CNT_W'(WORD_W - 1)) begin
                    state   <= SH_IDLE;
                    bit_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign sdata    = shreg[WORD_W-1];
    assign busy     = (state == SH_SHIFT);
    assign sclk_out = !(state == SH_SHIFT && !clk_ext && phase < PH_W'(HALF));

    // Newly loaded word presents its MSB on the next cycle.
    p_load_msb_r3: assert property (@(posedge clk) disable iff (rst)
        load.valid |=> (busy && sdata == $past(load.word[WORD_W-1])));

    // Once idle, the shifter holds nothing but ones.
    p_idle_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (state == SH_IDLE) |-> (shreg == '1));

    // The bit counter never passes the word length.
    p_cnt_range_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bit_cnt < CNT_W'(WORD_W)));

    // The sixteenth shift ends the word.
    p_done_r10: assert property (@(posedge clk) disable iff (rst)
        (step && bit_cnt == CNT_W'(WORD_W - 1) && !load.valid) |=> !busy);

endmodule

// File: rtl/adc_serial_out.sv
module adc_serial_out
    import aso_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CLK_DIV     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_ext_clk,
    input  logic              sel_pipelined,
    input  logic              code_twos,
    input  logic              hold_n,
    input  logic              res_valid,
    input  logic [WORD_W-1:0] res_data,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdata,
    output logic              busy
);
    mode_t      mode;
    word_xfer_t load;
    logic       sclk_fall;
    logic       hold_fall;

    assign mode    = '{clk_ext: sel_ext_clk, pipelined: sel_pipelined};
    assign sclk_oe = ~sel_ext_clk;

    aso_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sclk_in   (sclk_in),
        .hold_n    (hold_n),
        .sclk_fall (sclk_fall),
        .hold_fall (hold_fall)
    );

    aso_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .code_twos (code_twos),
        .res_valid (res_valid),
        .res_data  (res_data),
        .hold_fall (hold_fall),
        .load      (load)
    );

    aso_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .clk_ext   (mode.clk_ext),
        .load      (load),
        .sclk_fall (sclk_fall),
        .sdata     (sdata),
        .busy      (busy),
        .sclk_out  (sclk_out)
    );

    // With an outside clock the generated clock never leaves its idle level.
    p_ext_idle_clk_r2: assert property (@(posedge clk) disable iff (rst)
        sel_ext_clk |-> sclk_out);

    // Nothing is pending when not busy and nothing loads: stays idle.
    p_idle_stays_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load.valid) |=> !busy);

endmodule

// File: tb/adc_serial_out_bench.sv
`timescale 1ns/1ps
module adc_serial_out_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_ext_clk = 1'b1;
    logic        sel_pipelined = 1'b0;
    logic        code_twos = 1'b0;
    logic        hold_n = 1'b1;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        sclk_in = 1'b0;
    logic        sclk_out, sclk_oe, sdata, busy;

    always #4 clk = ~clk;

    adc_serial_out u_adc_serial_out (
        .clk(clk), .rst(rst), .sel_ext_clk(sel_ext_clk), .sel_pipelined(sel_pipelined),
        .code_twos(code_twos), .hold_n(hold_n), .res_valid(res_valid), .res_data(res_data),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdata(sdata), .busy(busy)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit fin   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_word = 16'hFFFF;
    logic [15:0] m_pend = '0;
    logic [15:0] m_lw, m_coded;
    int          m_left = 0;
    int          m_phase = 0;
    bit          m_pv = 0;
    bit          hq[$];
    bit          m_hold_prev = 1;
    bit          m_fall, m_hf, m_ld, m_stp;
    logic        prev_sclk = 1'b1;
    logic [15:0] rx = '0;
    int          rx_n = 0;

    initial hq = '{0, 0, 0};

    always @(posedge clk) begin
        if (rst) begin
            m_word = 16'hFFFF; m_left = 0; m_pv = 0; m_phase = 0;
            hq = '{0, 0, 0}; m_hold_prev = 1;
        end else begin
            m_fall  = hq[2] && !hq[1];
            m_hf    = m_hold_prev && !hold_n;
            m_coded = res_data ^ (code_twos ? 16'h8000 : 16'h0000);
            m_ld    = 0;
            m_lw    = '0;
            if (sel_pipelined) begin
                if (m_hf && m_pv) begin m_ld = 1; m_lw = m_pend; end
                if (res_valid) begin m_pend = m_coded; m_pv = 1; end
                else if (m_ld) m_pv = 0;
            end else begin
                if (res_valid) begin m_ld = 1; m_lw = m_coded; end
                m_pv = 0;
            end
            if (m_ld) begin
                m_word = m_lw; m_left = 16; m_phase = 0;
            end else if (m_left > 0) begin
                m_stp = sel_ext_clk ? m_fall : (m_phase == 3);
                if (!sel_ext_clk) m_phase = (m_phase + 1) % 4;
                if (m_stp) begin m_word = {m_word[14:0], 1'b1}; m_left--; end
            end
            void'(hq.pop_back());
            hq.push_front(sclk_in);
            m_hold_prev = hold_n;
        end
        #3;
        if (!fin) begin
            chk("R3 sdata", sdata, m_word[15]);
            chk("R10 busy", busy, m_left > 0);
            chk("R5 sclk_out", sclk_out, !(m_left > 0 && !sel_ext_clk && m_phase < 2));
            chk("R2 sclk_oe", sclk_oe, !sel_ext_clk);
        end
        if (!prev_sclk && sclk_out) begin rx = {rx[14:0], sdata}; rx_n++; end
        prev_sclk = sclk_out;
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !fin) begin
            fin = 1;
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_reset(input logic ext, input logic pipe, input logic twos);
        @(negedge clk);
        rst = 1; sel_ext_clk = ext; sel_pipelined = pipe; code_twos = twos;
        sclk_in = 0; hold_n = 1; res_valid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic strobe(input logic [15:0] w);
        @(negedge clk);
        res_valid = 1; res_data = w;
        @(negedge clk);
        res_valid = 0;
    endtask

    task automatic hold_pulse();
        @(negedge clk);
        hold_n = 0;
        @(negedge clk);
        hold_n = 1;
    endtask

    task automatic ext_bit(output logic b);
        @(negedge clk);
        sclk_in = 1;
        b = sdata;
        repeat (6) @(negedge clk);
        sclk_in = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic ext_bits(input int n, output logic [15:0] w);
        logic b;
        w = '0;
        for (int i = 0; i < n; i++) begin
            ext_bit(b);
            w = {w[14:0], b};
        end
    endtask

    initial begin
        logic [15:0] w, w2;
        logic        b;

        // R1: reset state
        do_reset(1, 0, 0);
        chk("R1 sdata idle", sdata, 1);
        chk("R1 busy idle", busy, 0);
        chk("R1 sclk_out idle", sclk_out, 1);
        chk("R2 oe ext", sclk_oe, 0);

        // External clock, immediate delivery
        strobe(16'h5A3C);
        chk("R6 msb on strobe", sdata, 0);
        chk("R10 busy after load", busy, 1);
        ext_bits(16, w);
        chk("R3 ext word", w, 16'h5A3C);
        chk("R10 busy after 16", busy, 0);
        ext_bit(b); chk("R4 surplus bit 17", b, 1);
        ext_bit(b); chk("R4 surplus bit 18", b, 1);

        // R6: new strobe replaces a word in flight
        strobe(16'hC001);
        ext_bits(3, w);
        chk("R6 first bits", w, 16'h0006);
        strobe(16'h0FF0);
        chk("R6 replaced msb", sdata, 0);
        ext_bits(16, w);
        chk("R6 replaced word", w, 16'h0FF0);

        // External clock, pipelined, two's complement
        do_reset(1, 1, 1);
        strobe(16'h1234);
        ext_bit(b); chk("R7 held not sent", b, 1);
        chk("R7 idle before hold", busy, 0);
        hold_pulse();
        chk("R7 msb after hold", sdata, 1);
        ext_bits(16, w);
        chk("R9 twos word", w, 16'h9234);

        // R12 and R8: hold edges mid-shift
        do_reset(1, 1, 0);
        strobe(16'hBEEF);
        hold_pulse();
        ext_bits(5, w);
        hold_pulse();
        chk("R12 still busy", busy, 1);
        ext_bits(11, w2);
        chk("R12 word intact", {w[4:0], w2[10:0]}, 16'hBEEF);
        strobe(16'h7777);
        hold_pulse();
        ext_bits(4, w);
        strobe(16'h0A0A);
        hold_pulse();
        chk("R8 new msb", sdata, 0);
        ext_bits(16, w);
        chk("R8 new word", w, 16'h0A0A);

        // Internal clock, immediate, with stray sclk_in activity
        do_reset(0, 0, 0);
        chk("R2 oe int", sclk_oe, 1);
        rx_n = 0;
        strobe(16'hA5F0);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (i % 3 == 0) sclk_in = ~sclk_in;
        end
        sclk_in = 0;
        chk("R5 pulse count", rx_n, 16);
        chk("R11 int word", rx, 16'hA5F0);
        chk("R10 busy done int", busy, 0);
        chk("R5 sclk idle high", sclk_out, 1);

        // Internal clock, pipelined, two's complement
        do_reset(0, 1, 1);
        strobe(16'h0123);
        repeat (10) @(negedge clk);
        chk("R7 int held idle", busy, 0);
        rx_n = 0;
        hold_pulse();
        repeat (70) @(negedge clk);
        chk("R5 int pipe count", rx_n, 16);
        chk("R9 int twos word", rx, 16'h8123);

        fin = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule